// File: doc/BRIEF.md
# Scripted Waveform Command Sequencer

This block is the command front end of a tone transmitter. It turns a stream of 32-bit register-write words into the settings that a downstream oscillator needs: an amplitude, a frequency and a chirp rate, together with a transmitter-enable flag. Each word carries a 4-bit register selector in its top bits and a 28-bit value below it. Some selectors do more than load a register. One kind of write switches the transmitter on or off. Two others pause the script, either for a number of cycles or until an external sync pulse arrives.

Words reach the block by two paths. The first is a script stream with a valid/ready handshake, normally fed by a memory fetch unit. The second is a direct host write port that is always accepted and takes priority over the script. This lets a host drive the transmitter by hand or interrupt a script. While the transmitter is enabled, the frequency register adds the chirp rate on every sample strobe, which produces a linear frequency sweep.

Top module: `wcs_seq`

## Requirements
- R1: A word is split into selector [31:28] and value [27:0]. Selector 0 loads the amplitude output and selector 1 loads the chirp-rate output; the new value appears on the clock edge that accepts the word. With no accepted word, neither output changes.
- R2: Selector 2 with a non-zero value loads the frequency output and sets tx_en on the accepting edge.
- R3: Selector 2 with a zero value loads a zero frequency and clears tx_en.
- R4: Selector 3 with value N holds scr_ready low for exactly the N cycles after the accepting cycle. N = 0 causes no pause.
- R5: Selector 4 holds scr_ready low until the cycle after a sync_pulse is seen. A sync_pulse that arrives while no sync wait is pending has no effect.
- R6: While host_valid is high, scr_ready is low, the script word is not consumed and the host word is executed.
- R7: An accepted host word cancels any timed or sync wait in progress, so scr_ready is high in the next cycle unless the host word itself starts a wait.
- R8: When tx_en is high and sample_stb is high, the frequency adds the chirp rate as a 28-bit two's-complement value, wrapping modulo 2^28. In that same cycle, a frequency write takes precedence over the addition, and a chirp write only takes effect from the next strobe.
- R9: Selectors 5 to 15 change no output and start no wait.
- R10: After reset, amplitude, chirp rate and frequency are zero, tx_en is low and scr_ready is high while host_valid is low.
- R11: While tx_en is low, sample_stb leaves the frequency unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| scr_valid | input | 1 | Script word offered |
| scr_instr | input | 32 | Script word |
| scr_ready | output | 1 | Script word taken this cycle when valid |
| host_valid | input | 1 | Host write strobe, always accepted |
| host_instr | input | 32 | Host word |
| sync_pulse | input | 1 | External synchronisation event |
| sample_stb | input | 1 | Oscillator sample strobe, drives the chirp step |
| amp_o | output | 28 | Current amplitude |
| chirp_o | output | 28 | Current chirp rate (two's complement) |
| freq_o | output | 28 | Current frequency |
| tx_en | output | 1 | Transmitter enable |

## Verification
The hardest cases to reach from the ports are the collisions that happen inside a single cycle. One is a host word arriving during a pause that the script itself started. Another is a sample strobe landing in the same cycle as a frequency or chirp write. The stimulus builds these cases deliberately. It starts a long timed wait and a sync wait from the script, then breaks each one with a host write. It also offers script and host words together, and pairs strobes with writes under a negative chirp. A bench model works out, cycle by cycle, which source wins and when the script is let through again.

// File: rtl/wcs_pkg.sv
`timescale 1ns/1ps
package wcs_pkg;
  localparam int SEL_W   = 4;
  localparam int VAL_W   = 28;
  localparam int INSTR_W = SEL_W + VAL_W;

  localparam logic [SEL_W-1:0] SEL_AMP   = 4'd0;
  localparam logic [SEL_W-1:0] SEL_CHIRP = 4'd1;
  localparam logic [SEL_W-1:0] SEL_FREQ  = 4'd2;
  localparam logic [SEL_W-1:0] SEL_TWAIT = 4'd3;
  localparam logic [SEL_W-1:0] SEL_SWAIT = 4'd4;

  function automatic logic [SEL_W-1:0] word_sel(input logic [INSTR_W-1:0] w);
    return w[INSTR_W-1 -: SEL_W];
  endfunction

  function automatic logic [VAL_W-1:0] word_val(input logic [INSTR_W-1:0] w);
    return w[VAL_W-1:0];
  endfunction

  // two's-complement step; same width so wrap is modulo 2^VAL_W
  function automatic logic [VAL_W-1:0] sweep_next(input logic [VAL_W-1:0] f,
                                                  input logic [VAL_W-1:0] rate);
    return f + rate;
  endfunction
endpackage

// File: rtl/wcs_src_mux.sv
`timescale 1ns/1ps
module wcs_src_mux #(
  parameter int W = 32
) (
  input  logic         host_valid,
  input  logic [W-1:0] host_instr,
  input  logic         scr_valid,
  input  logic [W-1:0] scr_instr,
  input  logic         busy,
  output logic         scr_ready,
  output logic         acc_valid,
  output logic         acc_host,
  output logic [W-1:0] acc_instr
);
  assign scr_ready = !busy && !host_valid;
  assign acc_host  = host_valid;
  assign acc_valid = host_valid || (scr_valid && scr_ready);
  assign acc_instr = host_valid ? host_instr : scr_instr;
endmodule

// File: rtl/wcs_wait_ctl.sv
`timescale 1ns/1ps
module wcs_wait_ctl #(
  parameter int CNT_W = 28
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cancel,
  input  logic             load_timed,
  input  logic             load_sync,
  input  logic [CNT_W-1:0] load_val,
  input  logic             sync_pulse,
  output logic             timed_busy,
  output logic             sync_busy,
  output logic             busy
);
  logic [CNT_W-1:0] remain;
  logic             sync_pend;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      remain    <= '0;
      sync_pend <= 1'b0;
    end else begin
      if (cancel) begin
        remain    <= '0;
        sync_pend <= 1'b0;
      end else begin
        if (remain != '0)
          remain <= remain - 1'b1;
        if (sync_pend && sync_pulse)
          sync_pend <= 1'b0;
      end
      if (load_timed) remain    <= load_val;
      if (load_sync)  sync_pend <= 1'b1;
    end
  end

  assign timed_busy = (remain != '0);
  assign sync_busy  = sync_pend;
  assign busy       = timed_busy || sync_pend;
endmodule

// File: rtl/wcs_tone_regs.sv
`timescale 1ns/1ps
module wcs_tone_regs
  import wcs_pkg::*;
#(
  parameter int W = VAL_W
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_amp,
  input  logic         wr_chirp,
  input  logic         wr_freq,
  input  logic [W-1:0] wr_val,
  input  logic         sample_stb,
  output logic [W-1:0] amp,
  output logic [W-1:0] chirp,
  output logic [W-1:0] freq,
  output logic         tx_en,
  output logic         step_en
);
  assign step_en = tx_en && sample_stb && !wr_freq;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      amp   <= '0;
      chirp <= '0;
      freq  <= '0;
      tx_en <= 1'b0;
    end else begin
      if (wr_amp)   amp   <= wr_val;
      if (wr_chirp) chirp <= wr_val;
      if (wr_freq) begin
        freq  <= wr_val;
        tx_en <= (wr_val != '0);
      end else if (step_en) begin
        freq  <= sweep_next(freq, chirp);
      end
    end
  end
endmodule

// File: rtl/wcs_seq.sv
`timescale 1ns/1ps
module wcs_seq
  import wcs_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               scr_valid,
  input  logic [INSTR_W-1:0] scr_instr,
  output logic               scr_ready,
  input  logic               host_valid,
  input  logic [INSTR_W-1:0] host_instr,
  input  logic               sync_pulse,
  input  logic               sample_stb,
  output logic [VAL_W-1:0]   amp_o,
  output logic [VAL_W-1:0]   chirp_o,
  output logic [VAL_W-1:0]   freq_o,
  output logic               tx_en
);
  logic               acc_valid;
  logic               acc_host;
  logic [INSTR_W-1:0] acc_instr;
  logic [SEL_W-1:0]   acc_sel;
  logic [VAL_W-1:0]   acc_val;
  logic               busy, timed_busy, sync_busy;
  logic               wr_amp, wr_chirp, wr_freq, wr_twait, wr_swait, wr_ign;
  logic               step_en;

  wcs_src_mux #(.W(INSTR_W)) u_mux (
    .host_valid (host_valid),
    .host_instr (host_instr),
    .scr_valid  (scr_valid),
    .scr_instr  (scr_instr),
    .busy       (busy),
    .scr_ready  (scr_ready),
    .acc_valid  (acc_valid),
    .acc_host   (acc_host),
    .acc_instr  (acc_instr)
  );

  assign acc_sel  = word_sel(acc_instr);
  assign acc_val  = word_val(acc_instr);
  assign wr_amp   = acc_valid && (acc_sel == SEL_AMP);
  assign wr_chirp = acc_valid && (acc_sel == SEL_CHIRP);
  assign wr_freq  = acc_valid && (acc_sel == SEL_FREQ);
  assign wr_twait = acc_valid && (acc_sel == SEL_TWAIT);
  assign wr_swait = acc_valid && (acc_sel == SEL_SWAIT);
  assign wr_ign   = acc_valid && (acc_sel > SEL_SWAIT);

  wcs_wait_ctl #(.CNT_W(VAL_W)) u_wait (
    .clk        (clk),
    .rst_n      (rst_n),
    .cancel     (acc_host),
    .load_timed (wr_twait),
    .load_sync  (wr_swait),
    .load_val   (acc_val),
    .sync_pulse (sync_pulse),
    .timed_busy (timed_busy),
    .sync_busy  (sync_busy),
    .busy       (busy)
  );

  wcs_tone_regs #(.W(VAL_W)) u_regs (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_amp     (wr_amp),
    .wr_chirp   (wr_chirp),
    .wr_freq    (wr_freq),
    .wr_val     (acc_val),
    .sample_stb (sample_stb),
    .amp        (amp_o),
    .chirp      (chirp_o),
    .freq       (freq_o),
    .tx_en      (tx_en),
    .step_en    (step_en)
  );
endmodule

// File: rtl/wcs_seq_chk.sv
`timescale 1ns/1ps
module wcs_seq_chk
  import wcs_pkg::*;
(
  input logic               clk,
  input logic               rst_n,
  input logic               host_valid,
  input logic [INSTR_W-1:0] host_instr,
  input logic               scr_valid,
  input logic               scr_ready,
  input logic               sync_pulse,
  input logic [VAL_W-1:0]   amp_o,
  input logic [VAL_W-1:0]   chirp_o,
  input logic [VAL_W-1:0]   freq_o,
  input logic               tx_en,
  input logic               acc_valid,
  input logic [VAL_W-1:0]   acc_val,
  input logic               wr_freq,
  input logic               wr_ign,
  input logic               step_en,
  input logic               timed_busy,
  input logic               sync_busy,
  input logic               busy
);
  a_r1_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !acc_valid |=> $stable(amp_o) && $stable(chirp_o));

  a_r2_freq_load: assert property (@(posedge clk) disable iff (!rst_n)
    wr_freq |=> (freq_o == $past(acc_val)) && (tx_en == ($past(acc_val) != '0)));

  a_r3_zero_off: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_freq && acc_val == '0) |=> !tx_en);

  a_r4_timed_stall: assert property (@(posedge clk) disable iff (!rst_n)
    timed_busy |-> !scr_ready);

  a_r5_sync_release: assert property (@(posedge clk) disable iff (!rst_n)
    (sync_busy && sync_pulse && !host_valid) |=> !sync_busy);

  a_r6_host_blocks: assert property (@(posedge clk) disable iff (!rst_n)
    host_valid |-> !scr_ready);

  a_r6_host_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (host_valid && scr_valid && word_sel(host_instr) == SEL_AMP)
      |=> amp_o == $past(word_val(host_instr)));

  a_r7_cancel: assert property (@(posedge clk) disable iff (!rst_n)
    (host_valid && word_sel(host_instr) > SEL_SWAIT) |=> !busy);

  a_r8_sweep: assert property (@(posedge clk) disable iff (!rst_n)
    step_en |=> freq_o == $past(freq_o) + $past(chirp_o));

  a_r9_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_ign && !step_en) |=> $stable(amp_o) && $stable(chirp_o)
                             && $stable(freq_o) && $stable(tx_en));

  a_r11_idle_freq: assert property (@(posedge clk) disable iff (!rst_n)
    (!tx_en && !wr_freq) |=> $stable(freq_o));
endmodule

bind wcs_seq wcs_seq_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .host_valid (host_valid),
  .host_instr (host_instr),
  .scr_valid  (scr_valid),
  .scr_ready  (scr_ready),
  .sync_pulse (sync_pulse),
  .amp_o      (amp_o),
  .chirp_o    (chirp_o),
  .freq_o     (freq_o),
  .tx_en      (tx_en),
  .acc_valid  (acc_valid),
  .acc_val    (acc_val),
  .wr_freq    (wr_freq),
  .wr_ign     (wr_ign),
  .step_en    (step_en),
  .timed_busy (timed_busy),
  .sync_busy  (sync_busy),
  .busy       (busy)
);

// File: tb/tb_wcs_seq.sv
`timescale 1ns/1ps
module tb_wcs_seq;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        scr_valid, host_valid, sync_pulse, sample_stb;
  logic [31:0] scr_instr, host_instr;
  logic        scr_ready, tx_en;
  logic [27:0] amp_o, chirp_o, freq_o;

  always #2 clk = ~clk;

  wcs_seq dut (
    .clk(clk), .rst_n(rst_n),
    .scr_valid(scr_valid), .scr_instr(scr_instr), .scr_ready(scr_ready),
    .host_valid(host_valid), .host_instr(host_instr),
    .sync_pulse(sync_pulse), .sample_stb(sample_stb),
    .amp_o(amp_o), .chirp_o(chirp_o), .freq_o(freq_o), .tx_en(tx_en)
  );

  typedef struct {
    string       req;
    logic [27:0] amp, chirp, freq;
    logic        tx;
  } exp_t;

  exp_t q[$];
  exp_t e;
  int   n_cmp = 0;
  int   n_bad = 0;
  bit   done  = 0;
  bit   took;

  logic [27:0] m_amp = '0, m_chirp = '0, m_freq = '0;
  logic        m_tx = 1'b0;
  int          m_cnt = 0;
  bit          m_sync = 0;

  task automatic note(input string req, input string what,
                      input logic [31:0] act, input logic [31:0] exp_v);
    n_cmp++;
    if (act !== exp_v) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp_v);
    end
  endtask

  function automatic logic [31:0] mk(input int s, input logic [27:0] v);
    return {s[3:0], v};
  endfunction

  // monitor: compare queued expectations just after the edge that produced them
  initial begin
    forever begin
      @(posedge clk);
      #1;
      while (q.size() > 0) begin
        e = q.pop_front();
        note(e.req, "amp",   {4'h0, amp_o},   {4'h0, e.amp});
        note(e.req, "chirp", {4'h0, chirp_o}, {4'h0, e.chirp});
        note(e.req, "freq",  {4'h0, freq_o},  {4'h0, e.freq});
        note(e.req, "tx_en", {31'h0, tx_en},  {31'h0, e.tx});
      end
    end
  end

  // driver: apply one cycle of stimulus, predict, push expectation
  task automatic step(input string req, input bit hv, input logic [31:0] hi,
                      input bit sv, input logic [31:0] si,
                      input bit syn, input bit stb, output bit consumed);
    logic [31:0] ins;
    logic [27:0] nf;
    bit          acc, rdy;
    exp_t        x;
    @(negedge clk);
    host_valid = hv; host_instr = hi;
    scr_valid  = sv; scr_instr  = si;
    sync_pulse = syn; sample_stb = stb;
    #1;
    rdy = !((m_cnt != 0) || m_sync) && !hv;
    note(req, "scr_ready", {31'h0, scr_ready}, {31'h0, rdy});
    acc = 0; consumed = 0; ins = '0;
    if (hv) begin ins = hi; acc = 1; end
    else if (sv && rdy) begin ins = si; acc = 1; consumed = 1; end
    nf = m_freq;
    if (m_tx && stb) nf = m_freq + m_chirp;
    if (hv) begin m_cnt = 0; m_sync = 0; end
    else begin
      if (m_cnt != 0) m_cnt--;
      if (m_sync && syn) m_sync = 0;
    end
    if (acc) begin
      case (ins[31:28])
        4'd0: m_amp = ins[27:0];
        4'd1: m_chirp = ins[27:0];
        4'd2: begin nf = ins[27:0]; m_tx = (ins[27:0] != '0); end
        4'd3: m_cnt = int'(ins[27:0]);
        4'd4: m_sync = 1;
        default: ;
      endcase
    end
    m_freq = nf;
    x.req = req; x.amp = m_amp; x.chirp = m_chirp; x.freq = m_freq; x.tx = m_tx;
    q.push_back(x);
    @(posedge clk);
  endtask

  task automatic idle(input string req);
    step(req, 0, '0, 0, '0, 0, 0, took);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_bad++;
      n_cmp++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    rst_n = 0; scr_valid = 0; host_valid = 0; sync_pulse = 0; sample_stb = 0;
    scr_instr = '0; host_instr = '0;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1;

    // R10 reset state; R11 strobe while disabled
    idle("R10");
    step("R11", 0, '0, 0, '0, 0, 1, took);

    // R1 amplitude and chirp loads
    step("R1", 0, '0, 1, mk(0, 28'h0ABCDEF), 0, 0, took);
    step("R1", 0, '0, 1, mk(1, 28'hFFFFFFD), 0, 0, took);
    idle("R1");

    // R2 non-zero frequency turns on
    step("R2", 0, '0, 1, mk(2, 28'h0001000), 0, 0, took);

    // R8 negative sweep, write precedence, old rate on rate write
    for (int i = 0; i < 3; i++) step("R8", 0, '0, 0, '0, 0, 1, took);
    step("R8", 0, '0, 1, mk(2, 28'h0002000), 0, 1, took);
    step("R8", 0, '0, 1, mk(1, 28'h0000005), 0, 1, took);
    step("R8", 1, mk(2, 28'hFFFFFFE), 0, '0, 0, 0, took);
    step("R8", 0, '0, 0, '0, 0, 1, took);
    step("R8", 0, '0, 0, '0, 0, 1, took);

    // R3 zero frequency turns off; R11 no sweep afterwards
    step("R3", 0, '0, 1, mk(2, 28'h0), 0, 0, took);
    step("R11", 0, '0, 0, '0, 0, 1, took);

    // R4 timed pause of 3 cycles, then of 0
    step("R4", 0, '0, 1, mk(3, 28'd3), 0, 0, took);
    for (int i = 0; i < 5; i++) step("R4", 0, '0, 1, mk(0, 28'h0000111), 0, 0, took);
    step("R4", 0, '0, 1, mk(3, 28'd0), 0, 0, took);
    step("R4", 0, '0, 1, mk(0, 28'h0000112), 0, 0, took);

    // R5 stray pulse ignored, sync pause released by pulse
    step("R5", 0, '0, 0, '0, 1, 0, took);
    step("R5", 0, '0, 1, mk(4, 28'h0), 0, 0, took);
    for (int i = 0; i < 3; i++) step("R5", 0, '0, 1, mk(0, 28'h0000222), 0, 0, took);
    step("R5", 0, '0, 1, mk(0, 28'h0000222), 1, 0, took);
    step("R5", 0, '0, 1, mk(0, 28'h0000223), 0, 0, took);

    // R6 host and script together
    step("R6", 1, mk(0, 28'h0000333), 1, mk(0, 28'h0000444), 0, 0, took);
    step("R6", 0, '0, 1, mk(0, 28'h0000444), 0, 0, took);
    idle("R6");

    // R7 host cancels long timed pause and sync pause
    step("R7", 0, '0, 1, mk(3, 28'd100), 0, 0, took);
    idle("R7");
    step("R7", 1, mk(1, 28'h0000007), 0, '0, 0, 0, took);
    step("R7", 0, '0, 1, mk(0, 28'h0000555), 0, 0, took);
    step("R7", 0, '0, 1, mk(4, 28'h0), 0, 0, took);
    idle("R7");
    step("R7", 1, mk(9, 28'h1234567), 0, '0, 0, 0, took);
    idle("R7");

    // R9 unused selectors, with the transmitter running
    step("R9", 0, '0, 1, mk(2, 28'h0000100), 0, 0, took);
    step("R9", 0, '0, 1, mk(7, 28'hFFFFFFF), 0, 0, took);
    step("R9", 0, '0, 1, mk(15, 28'h0000001), 0, 0, took);
    idle("R9");

    @(posedge clk);
    #2;
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule